// File: doc/BRIEF.md
# Prioritised Address Window Chip-Select Decoder

This block sits in front of an external bus interface and decides, for every 24-bit bus address, which set of bus characteristics applies. Four programmable address windows are compared against the address in parallel. A window is described by an enable bit, a base page and a size code. The page is address bits 23:12. The size is 4 Kbytes shifted left by the code, so a window can cover anything from 4 Kbytes to 4 Mbytes. The base is aligned to the size: page bits below the size are ignored. An address that no enabled window covers falls back to parameter set 0.

When windows overlap, the higher-numbered window takes the address. This holds inside each pair (4 over 3, 2 over 1) and also between the pairs. The selected set index drives a group of four active-low chip-selects: one for the default region and one each for windows 1 to 3. The chip-selects can follow the address combinationally, or they can be captured once per access on the rising edge of the access-valid strobe. In parallel, the segment address lines (address bits 21:16) are masked to the configured external space size.

Top module: `cs_window_decoder`

## Requirements
- R1: After reset, with latched mode selected and `valid_i` low, every bit of `cs_n_o` is 1.
- R2: Window k (k = 1..4) matches when its enable bit is 1 and `addr_i[23:12]` equals its 12-bit base page, with the low `c` bits of both ignored. Here `c` is its 4-bit size code, and any code above 10 counts as 10.
- R3: A disabled window never matches. An address that no enabled window matches gives `sel_idx_o` = 0.
- R4: When several windows match, the highest-numbered one is selected: 4 before 3, 3 before 2, 2 before 1.
- R5: `sel_idx_o` is 0 for the default set or k for window k. It is a combinational function of the address and the window settings, valid in the same cycle.
- R6: Decoded chip-selects are active low. Bit 0 is low for the default set and bit k is low for window k (k = 1..3). A window-4 access drives all bits high. At most one bit is low.
- R7: With `cs_unlatched_i` = 1, `cs_n_o` is the decode of the current address, with no dependence on `valid_i` or on the clock.
- R8: With `cs_unlatched_i` = 0, `cs_n_o` takes the decode of the address present at the clock edge where `valid_i` is 1 after being 0 at the previous edge. It then holds that value while `valid_i` stays 1, even if the address changes.
- R9: With `cs_unlatched_i` = 0, `cs_n_o` is all ones from the first clock edge at which `valid_i` is 0.
- R10: `seg_o[j]` equals `addr_i[16+j]` for j < 2*`space_sel_i` and is 0 otherwise. Space code 0 means 64 Kbytes (no lines), 1 means 256 Kbytes (2 lines), 2 means 1 Mbyte (4 lines) and 3 means 4 Mbytes (6 lines).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 24 | Bus address |
| valid_i | input | 1 | Access-valid strobe |
| win_en_i | input | 4 | Enable bit per window, bit k-1 is window k |
| win_base_i | input | 48 | Base page per window, window k in bits 12k-1:12(k-1) |
| win_size_i | input | 16 | Size code per window, window k in bits 4k-1:4(k-1) |
| cs_unlatched_i | input | 1 | 1: chip-selects follow the address; 0: captured per access |
| space_sel_i | input | 2 | External space size code |
| sel_idx_o | output | 3 | Selected parameter set index |
| cs_n_o | output | 4 | Active-low chip-selects |
| seg_o | output | 6 | Masked segment address lines |

## Verification
The set index, the segment lines and the unlatched chip-selects are due in the same cycle as the address. The bench applies an address and samples these outputs one time step later, with no clock edge in between. In latched mode the chip-selects change one clock edge after a rising or falling strobe. The bench drives the strobe on the falling clock edge and samples at the next falling edge. It also samples just after the drive, to confirm the old value is still held. A change of address in the middle of an access is checked both before and after the following edge.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;
  localparam int unsigned ADDR_W   = 24;
  localparam int unsigned PAGE_LSB = 12;
  localparam int unsigned PAGE_W   = ADDR_W - PAGE_LSB;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned MAX_CODE = 10;
  localparam int unsigned SEG_LSB  = 16;
  localparam int unsigned SEG_W    = 6;
  localparam int unsigned SPACE_W  = 2;
  localparam int unsigned NUM_WIN  = 4;
  localparam int unsigned NUM_CS   = 4;
endpackage

// File: rtl/cs_win_match.sv
module cs_win_match #(
  parameter int unsigned PAGE_W   = 12,
  parameter int unsigned CODE_W   = 4,
  parameter int unsigned MAX_CODE = 10
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic              en_i,
  input  logic [PAGE_W-1:0] base_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              hit_o
);
  logic [CODE_W-1:0] code_c;
  logic [PAGE_W-1:0] keep;

  // codes past the largest window clamp to it
  always_comb begin
    code_c = (code_i > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code_i;
    for (int j = 0; j < PAGE_W; j++) begin
      keep[j] = (j >= int'(code_c));
    end
  end

  assign hit_o = en_i && (((page_i ^ base_i) & keep) == '0);
endmodule

// File: rtl/cs_prio_sel.sv
module cs_prio_sel #(
  parameter int unsigned NUM_WIN = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_WIN + 1)
) (
  input  logic [NUM_WIN-1:0] hit_i,
  output logic [IDX_W-1:0]   idx_o
);
  // later (higher) windows overwrite earlier ones
  always_comb begin
    idx_o = '0;
    for (int k = 0; k < NUM_WIN; k++) begin
      if (hit_i[k]) idx_o = IDX_W'(k + 1);
    end
  end
endmodule

// File: rtl/cs_line_map.sv
module cs_line_map #(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned NUM_CS  = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_WIN + 1)
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [NUM_CS-1:0] cs_n_o
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_line
    assign cs_n_o[g] = (idx_i != IDX_W'(g));
  end
endmodule

// File: rtl/cs_seg_mask.sv
module cs_seg_mask #(
  parameter int unsigned SEG_W   = 6,
  parameter int unsigned SPACE_W = 2
) (
  input  logic [SEG_W-1:0]   seg_i,
  input  logic [SPACE_W-1:0] space_i,
  output logic [SEG_W-1:0]   seg_o
);
  // two address lines per step of space size
  always_comb begin
    for (int j = 0; j < SEG_W; j++) begin
      seg_o[j] = seg_i[j] && (j < 2 * int'(space_i));
    end
  end
endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
  import cs_dec_pkg::*;
#(
  parameter int unsigned N_WIN  = NUM_WIN,
  parameter int unsigned N_CS   = NUM_CS,
  localparam int unsigned IDX_W = $clog2(N_WIN + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     valid_i,
  input  logic [N_WIN-1:0]         win_en_i,
  input  logic [N_WIN*PAGE_W-1:0]  win_base_i,
  input  logic [N_WIN*CODE_W-1:0]  win_size_i,
  input  logic                     cs_unlatched_i,
  input  logic [SPACE_W-1:0]       space_sel_i,
  output logic [IDX_W-1:0]         sel_idx_o,
  output logic [N_CS-1:0]          cs_n_o,
  output logic [SEG_W-1:0]         seg_o
);
  logic [N_WIN-1:0] hit;
  logic [N_CS-1:0]  cs_dec;
  logic [N_CS-1:0]  cs_q;
  logic             valid_q;

  for (genvar k = 0; k < N_WIN; k++) begin : g_win
    cs_win_match #(.PAGE_W(PAGE_W), .CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) i_match (
      .page_i (addr_i[ADDR_W-1:PAGE_LSB]),
      .en_i   (win_en_i[k]),
      .base_i (win_base_i[k*PAGE_W +: PAGE_W]),
      .code_i (win_size_i[k*CODE_W +: CODE_W]),
      .hit_o  (hit[k])
    );
  end

  cs_prio_sel #(.NUM_WIN(N_WIN)) i_prio (
    .hit_i (hit),
    .idx_o (sel_idx_o)
  );

  cs_line_map #(.NUM_WIN(N_WIN), .NUM_CS(N_CS)) i_map (
    .idx_i  (sel_idx_o),
    .cs_n_o (cs_dec)
  );

  cs_seg_mask #(.SEG_W(SEG_W), .SPACE_W(SPACE_W)) i_seg (
    .seg_i   (addr_i[SEG_LSB +: SEG_W]),
    .space_i (space_sel_i),
    .seg_o   (seg_o)
  );

  // capture on strobe rise, release on strobe low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      cs_q    <= '1;
    end else begin
      valid_q <= valid_i;
      if (!valid_i)      cs_q <= '1;
      else if (!valid_q) cs_q <= cs_dec;
    end
  end

  assign cs_n_o = cs_unlatched_i ? cs_dec : cs_q;
endmodule

// File: rtl/cs_window_decoder_chk.sv
module cs_window_decoder_chk
  import cs_dec_pkg::*;
#(
  parameter int unsigned N_WIN  = NUM_WIN,
  parameter int unsigned N_CS   = NUM_CS,
  localparam int unsigned IDX_W = $clog2(N_WIN + 1)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [ADDR_W-1:0]       addr_i,
  input logic                    valid_i,
  input logic                    cs_unlatched_i,
  input logic [SPACE_W-1:0]      space_sel_i,
  input logic [IDX_W-1:0]        sel_idx_o,
  input logic [N_CS-1:0]         cs_n_o,
  input logic [SEG_W-1:0]        seg_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_one_cs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_n_o) <= 1);

  assert_idx_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_idx_o <= IDX_W'(N_WIN));

  assert_default_line_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_unlatched_i |-> ((sel_idx_o == '0) == !cs_n_o[0]));

  assert_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_unlatched_i && !valid_i) |=> (cs_unlatched_i || (&cs_n_o)));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && !cs_unlatched_i && $past(!cs_unlatched_i)
     && $past(valid_i) && $past(valid_i, 2)) |-> $stable(cs_n_o));

  assert_seg_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (space_sel_i == '0) |-> (seg_o == '0));

  assert_seg_top_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (space_sel_i != 2'd3) |-> (seg_o[SEG_W-1:SEG_W-2] == 2'b00));
endmodule

bind cs_window_decoder cs_window_decoder_chk #(.N_WIN(N_WIN), .N_CS(N_CS)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .addr_i         (addr_i),
  .valid_i        (valid_i),
  .cs_unlatched_i (cs_unlatched_i),
  .space_sel_i    (space_sel_i),
  .sel_idx_o      (sel_idx_o),
  .cs_n_o         (cs_n_o),
  .seg_o          (seg_o)
);

// File: tb/test_cs_window_decoder.sv
module test_cs_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic        valid = 1'b0;
  logic [3:0]  en_v = '0;
  logic [47:0] base_v = '0;
  logic [15:0] code_v = '0;
  logic        unl = 1'b0;
  logic [1:0]  space = '0;
  logic [2:0]  sel_idx;
  logic [3:0]  cs_n;
  logic [5:0]  seg;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cs_window_decoder i_cs_window_decoder (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .valid_i(valid),
    .win_en_i(en_v), .win_base_i(base_v), .win_size_i(code_v),
    .cs_unlatched_i(unl), .space_sel_i(space),
    .sel_idx_o(sel_idx), .cs_n_o(cs_n), .seg_o(seg)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h addr=%06h", req, act, exp, addr);
    end
  endtask

  function automatic int ref_sel(logic [23:0] a);
    int r = 0;
    for (int k = 0; k < 4; k++) begin
      int c;
      logic [11:0] m;
      c = int'(code_v[4*k +: 4]);
      if (c > 10) c = 10;
      m = 12'hFFF << c;
      if (en_v[k] && (((a[23:12] ^ base_v[12*k +: 12]) & m) == 12'h000)) r = k + 1;
    end
    return r;
  endfunction

  function automatic logic [3:0] ref_cs(int s);
    logic [3:0] v = 4'hF;
    if (s < 4) v[s] = 1'b0;
    return v;
  endfunction

  task automatic set_win(int k, bit en, logic [11:0] base, logic [3:0] code);
    en_v[k-1] = en;
    base_v[12*(k-1) +: 12] = base;
    code_v[4*(k-1) +: 4] = code;
  endtask

  task automatic probe(logic [23:0] a, int exp_sel, string req);
    addr = a;
    #1;
    check(int'(sel_idx) == exp_sel, req, int'(sel_idx), exp_sel);
  endtask

  task automatic sweep();
    for (int p = 0; p < 4096; p++) begin
      int s;
      addr = {p[11:0], 12'($urandom)};
      valid = $urandom_range(0, 1) == 1;
      #1;
      s = ref_sel(addr);
      check(int'(sel_idx) == s, "R4", int'(sel_idx), s);
      check(cs_n == ref_cs(s), "R7", int'(cs_n), int'(ref_cs(s)));
    end
    valid = 1'b0;
  endtask

  task automatic latched_access(logic [23:0] a, logic [23:0] b);
    logic [3:0] ea;
    @(negedge clk);
    addr = a;
    valid = 1'b1;
    ea = ref_cs(ref_sel(a));
    #1;
    check(cs_n == 4'hF, "R8", int'(cs_n), 15);
    @(negedge clk);
    check(cs_n == ea, "R8", int'(cs_n), int'(ea));
    addr = b;
    #1;
    check(cs_n == ea, "R8", int'(cs_n), int'(ea));
    @(negedge clk);
    check(cs_n == ea, "R8", int'(cs_n), int'(ea));
    valid = 1'b0;
    #1;
    check(cs_n == ea, "R8", int'(cs_n), int'(ea));
    @(negedge clk);
    check(cs_n == 4'hF, "R9", int'(cs_n), 15);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n == 4'hF, "R1", int'(cs_n), 15);

    // directed layout, windows overlap in and across pairs
    set_win(1, 1'b1, 12'h000, 4'd10);
    set_win(2, 1'b1, 12'h100, 4'd8);
    set_win(3, 1'b1, 12'h400, 4'd10);
    set_win(4, 1'b1, 12'h0C3, 4'd4);
    unl = 1'b1;
    probe(24'h000123, 1, "R2");
    probe(24'h150000, 2, "R4");
    probe(24'h0C5ABC, 4, "R4");
    probe(24'h0D0000, 1, "R2");
    probe(24'h401000, 3, "R2");
    probe(24'h900000, 0, "R3");
    check(cs_n == 4'b1110, "R6", int'(cs_n), 14);
    probe(24'h0C0000, 4, "R5");
    check(cs_n == 4'b1111, "R6", int'(cs_n), 15);
    probe(24'h150000, 2, "R5");
    check(cs_n == 4'b1011, "R6", int'(cs_n), 11);
    set_win(2, 1'b0, 12'h100, 4'd8);
    probe(24'h150000, 1, "R3");
    set_win(3, 1'b1, 12'h7FF, 4'd15);
    probe(24'h7FF000, 3, "R2");
    probe(24'h400000, 3, "R2");
    probe(24'h800000, 0, "R2");
    en_v = 4'h0;
    probe(24'h000000, 0, "R3");
    set_win(2, 1'b1, 12'h100, 4'd8);
    set_win(1, 1'b1, 12'h000, 4'd10);
    set_win(3, 1'b1, 12'h400, 4'd10);
    set_win(4, 1'b1, 12'h0C3, 4'd4);
    sweep();

    for (int r = 0; r < 12; r++) begin
      en_v = 4'($urandom);
      base_v = {16'($urandom), 32'($urandom)};
      code_v = 16'($urandom);
      sweep();
    end

    // latched mode with the directed layout
    set_win(1, 1'b1, 12'h000, 4'd10);
    set_win(2, 1'b1, 12'h100, 4'd8);
    set_win(3, 1'b1, 12'h400, 4'd10);
    set_win(4, 1'b1, 12'h0C3, 4'd4);
    unl = 1'b0;
    latched_access(24'h000100, 24'h900000);
    latched_access(24'h900000, 24'h150000);
    latched_access(24'h150000, 24'h401000);
    latched_access(24'h401000, 24'h000100);
    latched_access(24'h0C0000, 24'h900000);

    for (int s = 0; s < 4; s++) begin
      space = 2'(s);
      for (int v = 0; v < 64; v++) begin
        logic [5:0] e;
        addr = {2'($urandom), 6'(v), 16'($urandom)};
        #1;
        e = 6'(v) & ~(6'h3F << (2 * s));
        check(seg == e, "R10", int'(seg), int'(e));
      end
    end

    finish_run();
  end
endmodule